// File: doc/BRIEF.md
# Transmit Completion Auto-Release Handler

This block sits between a transmit engine and the host-facing packet bookkeeping. It tracks how many packets are queued for transmission and takes one completion event per finished packet. Each event carries a packet number and a success flag. A mode input, `auto_rel`, selects what a completion produces. With the mode set, a successful packet's buffer pages are freed at once with a release strobe, and nothing is reported for it. A failed packet halts the run: its number is kept for the host and its pages stay allocated. With the mode clear, every completed packet number is pushed toward a completion FIFO and raises the transmit interrupt. Pages are then never freed by the block.

The control is a three-state machine. `ST_IDLE` means no packets are pending, and any completion is ignored. `ST_BUSY` means at least one packet is pending and completions are accepted. `ST_HALT` means a failure has stopped transmission and completions are dropped. The transitions are named as follows:
- IDLE_TO_BUSY: an enqueue strobe in `ST_IDLE`.
- BUSY_TO_IDLE: a successful completion of the last pending packet with no enqueue in the same cycle.
- BUSY_TO_HALT: any failed completion.
- HALT_RESUME: a restart strobe. It leads to `ST_BUSY` if packets remain or one is enqueued, otherwise to `ST_IDLE`.

Two sticky interrupt flags are cleared by a write-one-to-clear acknowledge. All strobes last one cycle. Reset is synchronous and active high.

Top module: `txc_autorel_top`

## Requirements
- R1: While and right after reset, all strobes, both interrupt flags, `rel_pkt`, `push_pkt` and `fail_pkt` are zero, and no packets are pending.
- R2: With `auto_rel` high, an accepted completion with `done_ok` high gives `rel_stb` high for one cycle, with `rel_pkt` equal to the packet number. No FIFO push is made and `tx_irq` is not set.
- R3: `empty_irq` is set only by a successful completion that brings the pending count from one to zero. Earlier completions in the run do not set it.
- R4: An accepted completion with `done_ok` low is a failure, in either mode. It pulses `txen_clr`, sets `tx_irq` and loads `fail_pkt` with the packet number. It never pulses `rel_stb`.
- R5: After a failure, completions are ignored, and the pending count is left unchanged, until `restart_stb` is seen.
- R6: With `auto_rel` low, every accepted completion pulses `push_stb` with `push_pkt` equal to the packet number and sets `tx_irq`. `rel_stb` is never pulsed.
- R7: Each `enq_stb` adds one to the pending count, and each accepted completion subtracts one. Both in the same cycle leave the count unchanged. An enqueue when the count is at its maximum of 2^CNT_W-1 is ignored.
- R8: A completion that arrives while no packets are pending is ignored and has no output effect.
- R9: `irq_ack[0]` clears `tx_irq` and `irq_ack[1]` clears `empty_irq`. If a flag is set and acknowledged in the same cycle, it stays set.
- R10: `rel_stb`, `push_stb` and `txen_clr` are one-cycle pulses, and at most one of `rel_stb` and `push_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_rel | input | 1 | Auto-release mode select |
| enq_stb | input | 1 | One packet queued for transmission |
| done_vld | input | 1 | Completion event valid |
| done_pkt | input | PKT_W | Packet number of the completion |
| done_ok | input | 1 | Completion was successful |
| restart_stb | input | 1 | Host re-enables transmission after a failure |
| irq_ack | input | 2 | Write-one-to-clear: bit 0 tx_irq, bit 1 empty_irq |
| rel_stb | output | 1 | Page release request pulse |
| rel_pkt | output | PKT_W | Packet whose pages are to be freed |
| push_stb | output | 1 | Completion FIFO push pulse |
| push_pkt | output | PKT_W | Packet number to push |
| fail_pkt | output | PKT_W | Number of the last failed packet |
| tx_irq | output | 1 | Sticky transmit interrupt |
| empty_irq | output | 1 | Sticky transmit-empty interrupt |
| txen_clr | output | 1 | Pulse that clears the transmit-enable bit |

## Verification
Every result is registered once. A completion, enqueue or acknowledge driven before a rising edge shows its effect on the strobes, the packet outputs and the flags just after that edge, so every result is due exactly one cycle after its stimulus. The bench changes inputs on falling edges and reads outputs on the next falling edge. A scoreboard queue holds the expected release, push and failure events. The monitor pops that queue whenever a strobe appears, so a missing, extra or stretched pulse is caught. Flag and count behaviour is checked at the same half-cycle point after each stimulus.

// File: rtl/txc_pkg.sv
package txc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HALT = 2'd2
    } txc_state_e;

    localparam int unsigned IRQ_N   = 2;
    localparam int unsigned IRQ_TX  = 0;
    localparam int unsigned IRQ_EMP = 1;
endpackage

// File: rtl/txc_pend_cnt.sv
module txc_pend_cnt #(
    parameter int unsigned CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic is_zero,
    output logic is_last
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             inc_eff;
    logic             dec_eff;

    assign inc_eff = inc && (cnt != CNT_MAX);
    assign dec_eff = dec && (cnt != '0);
    assign is_zero = (cnt == '0);
    assign is_last = (cnt == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc_eff && !dec_eff) begin
            cnt <= cnt + CNT_ONE;
        end else if (dec_eff && !inc_eff) begin
            cnt <= cnt - CNT_ONE;
        end
    end

    // R7: count moves by at most one per cycle
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_ONE)
              || (cnt == $past(cnt) - CNT_ONE));
    // R7: saturates at maximum
    assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !dec) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/txc_irq_flags.sv
module txc_irq_flags
    import txc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_N-1:0] set_v,
    input  logic [IRQ_N-1:0] ack_v,
    output logic [IRQ_N-1:0] flag_v
);
    for (genvar g = 0; g < IRQ_N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_v[g] <= 1'b0;
            end else if (set_v[g]) begin
                flag_v[g] <= 1'b1;
            end else if (ack_v[g]) begin
                flag_v[g] <= 1'b0;
            end
        end

        // R9: a set always wins
        assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
            set_v[g] |=> flag_v[g]);
        // R9: a flag only rises because of a set
        assert_flag_rise_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_v[g]) |-> $past(set_v[g]));
    end
endmodule

// File: rtl/txc_fsm.sv
module txc_fsm
    import txc_pkg::*;
#(
    parameter int unsigned PKT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_rel,
    input  logic             enq_stb,
    input  logic             done_vld,
    input  logic [PKT_W-1:0] done_pkt,
    input  logic             done_ok,
    input  logic             restart_stb,
    input  logic             cnt_zero,
    input  logic             cnt_last,
    output logic             accept,
    output logic             set_tx,
    output logic             set_empty,
    output logic             rel_stb,
    output logic [PKT_W-1:0] rel_pkt,
    output logic             push_stb,
    output logic [PKT_W-1:0] push_pkt,
    output logic [PKT_W-1:0] fail_pkt,
    output logic             txen_clr
);
    txc_state_e state, state_nx;

    assign accept    = done_vld && (state == ST_BUSY);
    assign set_tx    = accept && (!auto_rel || !done_ok);
    assign set_empty = accept && done_ok && cnt_last && !enq_stb;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (enq_stb) state_nx = ST_BUSY;
            ST_BUSY: begin
                if (accept && !done_ok) begin
                    state_nx = ST_HALT;
                end else if (set_empty) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (restart_stb) begin
                    state_nx = (!cnt_zero || enq_stb) ? ST_BUSY : ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_stb  <= 1'b0;
            rel_pkt  <= '0;
            push_stb <= 1'b0;
            push_pkt <= '0;
            fail_pkt <= '0;
            txen_clr <= 1'b0;
        end else begin
            rel_stb  <= accept && auto_rel && done_ok;
            push_stb <= accept && !auto_rel;
            txen_clr <= accept && !done_ok;
            if (accept && auto_rel && done_ok) rel_pkt <= done_pkt;
            if (accept && !auto_rel) push_pkt <= done_pkt;
            if (accept && !done_ok) fail_pkt <= done_pkt;
        end
    end

    // R10: release and push never coincide
    assert_rel_push_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(rel_stb && push_stb));
    // R10: strobes are single-cycle when the event does not repeat
    assert_txen_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        txen_clr |=> !txen_clr);
    // R4: failed packet is never released
    assert_fail_no_rel_R4: assert property (@(posedge clk) disable iff (rst)
        txen_clr |-> !rel_stb);
    // R2: a release needs auto mode and a good completion
    assert_rel_cause_R2: assert property (@(posedge clk) disable iff (rst)
        rel_stb |-> $past(auto_rel && done_ok && done_vld));
    // R6: push only in non-auto mode
    assert_push_cause_R6: assert property (@(posedge clk) disable iff (rst)
        push_stb |-> $past(!auto_rel && done_vld));
    // R5: halt holds until restart
    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !restart_stb) |=> (state == ST_HALT));
    // R8: nothing is accepted while idle
    assert_idle_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !accept);
endmodule

// File: rtl/txc_autorel_top.sv
module txc_autorel_top
    import txc_pkg::*;
#(
    parameter int unsigned PKT_W = 6,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_rel,
    input  logic             enq_stb,
    input  logic             done_vld,
    input  logic [PKT_W-1:0] done_pkt,
    input  logic             done_ok,
    input  logic             restart_stb,
    input  logic [1:0]       irq_ack,
    output logic             rel_stb,
    output logic [PKT_W-1:0] rel_pkt,
    output logic             push_stb,
    output logic [PKT_W-1:0] push_pkt,
    output logic [PKT_W-1:0] fail_pkt,
    output logic             tx_irq,
    output logic             empty_irq,
    output logic             txen_clr
);
    logic             accept;
    logic             cnt_zero;
    logic             cnt_last;
    logic             set_tx;
    logic             set_empty;
    logic [IRQ_N-1:0] set_v;
    logic [IRQ_N-1:0] flag_v;

    txc_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (enq_stb),
        .dec     (accept),
        .is_zero (cnt_zero),
        .is_last (cnt_last)
    );

    txc_fsm #(.PKT_W(PKT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .auto_rel    (auto_rel),
        .enq_stb     (enq_stb),
        .done_vld    (done_vld),
        .done_pkt    (done_pkt),
        .done_ok     (done_ok),
        .restart_stb (restart_stb),
        .cnt_zero    (cnt_zero),
        .cnt_last    (cnt_last),
        .accept      (accept),
        .set_tx      (set_tx),
        .set_empty   (set_empty),
        .rel_stb     (rel_stb),
        .rel_pkt     (rel_pkt),
        .push_stb    (push_stb),
        .push_pkt    (push_pkt),
        .fail_pkt    (fail_pkt),
        .txen_clr    (txen_clr)
    );

    always_comb begin
        set_v          = '0;
        set_v[IRQ_TX]  = set_tx;
        set_v[IRQ_EMP] = set_empty;
    end

    txc_irq_flags u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_v  (set_v),
        .ack_v  (irq_ack),
        .flag_v (flag_v)
    );

    assign tx_irq    = flag_v[IRQ_TX];
    assign empty_irq = flag_v[IRQ_EMP];

    // R3: transmit-empty only follows a good completion
    assert_empty_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(empty_irq) |-> $past(done_ok && done_vld));
endmodule

// File: tb/txc_autorel_top_tb.sv
module txc_autorel_top_tb;
    localparam int PKT_W = 6;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             auto_rel = 1'b0;
    logic             enq_stb = 1'b0;
    logic             done_vld = 1'b0;
    logic [PKT_W-1:0] done_pkt = '0;
    logic             done_ok = 1'b0;
    logic             restart_stb = 1'b0;
    logic [1:0]       irq_ack = 2'b00;
    logic             rel_stb, push_stb, tx_irq, empty_irq, txen_clr;
    logic [PKT_W-1:0] rel_pkt, push_pkt, fail_pkt;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // scoreboard item: kind 0 release, 1 push, 2 failure
    typedef struct packed { logic [1:0] kind; logic [PKT_W-1:0] pkt; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    txc_autorel_top #(.PKT_W(PKT_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .auto_rel(auto_rel), .enq_stb(enq_stb),
        .done_vld(done_vld), .done_pkt(done_pkt), .done_ok(done_ok),
        .restart_stb(restart_stb), .irq_ack(irq_ack),
        .rel_stb(rel_stb), .rel_pkt(rel_pkt), .push_stb(push_stb),
        .push_pkt(push_pkt), .fail_pkt(fail_pkt), .tx_irq(tx_irq),
        .empty_irq(empty_irq), .txen_clr(txen_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pop_cmp(input string req, input logic [1:0] kind, input logic [PKT_W-1:0] pkt);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(req, {kind, pkt}, 32'hDEAD);
        end else begin
            e = exp_q.pop_front();
            check(req, {kind, pkt}, {e.kind, e.pkt});
        end
    endtask

    // monitor: R2 R6 R4 R10 strobes against scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (rel_stb)  pop_cmp("R2/R10 release", 2'd0, rel_pkt);
            if (push_stb) pop_cmp("R6/R10 push", 2'd1, push_pkt);
            if (txen_clr) pop_cmp("R4/R10 failure", 2'd2, fail_pkt);
        end
    end

    task automatic enq(input int n);
        for (int i = 0; i < n; i++) begin
            enq_stb = 1'b1;
            @(negedge clk);
            enq_stb = 1'b0;
        end
    endtask

    // kind -1: no result expected
    task automatic complete(input logic [PKT_W-1:0] p, input logic ok, input int kind,
                            input logic with_enq = 1'b0);
        exp_t e;
        if (kind >= 0) begin
            e.kind = kind[1:0];
            e.pkt  = p;
            exp_q.push_back(e);
        end
        done_vld = 1'b1; done_pkt = p; done_ok = ok; enq_stb = with_enq;
        @(negedge clk);
        done_vld = 1'b0; done_ok = 1'b0; enq_stb = 1'b0;
    endtask

    task automatic ack(input logic [1:0] a);
        irq_ack = a;
        @(negedge clk);
        irq_ack = 2'b00;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rel_stb", rel_stb, 0);
        check("R1 push_stb", push_stb, 0);
        check("R1 flags", {tx_irq, empty_irq, txen_clr}, 0);
        check("R1 pkts", {rel_pkt, push_pkt, fail_pkt}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {rel_stb, push_stb, tx_irq, empty_irq, txen_clr}, 0);

        // auto-release run of three good packets
        auto_rel = 1'b1;
        enq(3);
        complete(6'd5, 1'b1, 0);
        complete(6'd9, 1'b1, 0);
        check("R3 no empty mid-run", empty_irq, 0);
        check("R2 no tx_irq", tx_irq, 0);
        complete(6'd12, 1'b1, 0);
        check("R3 empty at end", empty_irq, 1);
        check("R2 no tx_irq end", tx_irq, 0);
        ack(2'b10);
        check("R9 ack empty", empty_irq, 0);

        // R8: completion with nothing pending
        complete(6'd33, 1'b1, -1);
        @(negedge clk);
        check("R8 ignored flags", {tx_irq, empty_irq}, 0);

        // failure in auto mode, then halt and restart
        enq(3);
        complete(6'd1, 1'b1, 0);
        complete(6'd2, 1'b0, 2);
        check("R4 tx_irq", tx_irq, 1);
        check("R4 fail_pkt", fail_pkt, 6'd2);
        check("R4 no empty", empty_irq, 0);
        complete(6'd3, 1'b1, -1);           // R5 dropped in halt
        @(negedge clk);
        check("R5 halt keeps empty low", empty_irq, 0);
        restart_stb = 1'b1;
        @(negedge clk);
        restart_stb = 1'b0;
        complete(6'd3, 1'b1, 0);            // R5 count still one
        check("R5 last after restart", empty_irq, 1);
        ack(2'b11);
        check("R9 ack both", {tx_irq, empty_irq}, 0);

        // non-auto mode
        auto_rel = 1'b0;
        enq(2);
        complete(6'd20, 1'b1, 1);
        check("R6 tx_irq", tx_irq, 1);
        irq_ack = 2'b01;                    // R9 set wins over ack
        complete(6'd21, 1'b1, 1);
        irq_ack = 2'b00;
        check("R9 set beats ack", tx_irq, 1);
        check("R3 empty non-auto", empty_irq, 1);
        ack(2'b11);

        // R7 simultaneous enqueue and completion
        auto_rel = 1'b1;
        enq(1);
        complete(6'd40, 1'b1, 0, 1'b1);
        check("R7 simultaneous no empty", empty_irq, 0);
        complete(6'd41, 1'b1, 0);
        check("R7 empty after net", empty_irq, 1);
        ack(2'b10);

        // R7 saturation: 16 enqueues, only 15 counted
        enq(16);
        for (int i = 0; i < 15; i++) begin
            complete(6'(i + 1), 1'b1, 0);
            if (i == 13) check("R7 not empty at 14", empty_irq, 0);
        end
        check("R7 empty at 15", empty_irq, 1);
        complete(6'd60, 1'b1, -1);
        @(negedge clk);
        check("R7 extra ignored", tx_irq, 0);

        repeat (2) @(negedge clk);
        check("R10 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule